// File: doc/BRIEF.md
# Timeslot Switch Connection-Memory Access Controller

This block is the processor-side access controller of a TDM timeslot switch. It owns a 256-entry connection memory and a small data-memory model. The processor sees four registers. With them it writes or reads single connection entries, reads received samples from the data memory, sets up a two-way connection in one step, and walks the connection memory from a start address up to the last location. The walk is either a fill with one value or a sequence of reads, one location per processor read.

A connection entry holds a loop flag above the index of the input slot that feeds the output slot at that address. The connection memory has a single port, and reads from the switching side always win it. The controller waits out each conflicting cycle and then completes its access. `busy_o` is high for the whole of every controller operation, and register writes made while it is high are dropped.

Top module: `tsw_cmem_ctrl`

## Requirements
- R1: After reset, busy_o is low and the destination, source, data and mode registers read as zero. Register offsets: 0 destination, 1 source, 2 data (bit 8 loop flag, bits 7..0 value), 3 mode (bit 0 rd, bit 1 cm, bit 2 bid, bit 3 cac).
- R2: A destination or source register value r maps to the slot index {r[7:6], r[4:0], r[5]}, so bit 5 is the least significant bit of the 6-bit timeslot number. A mode write with cm=1, rd=0, bid=0 and cac=0 stores {data[8], index(source)} at index(destination), and changes no other entry.
- R3: A mode write with cm=1, rd=1 and cac=0 loads the entry at index(destination) into the data register.
- R4: A mode write with cm=0 and rd=1 loads the data-memory word at the raw destination address into data[7:0] and clears data[8].
- R5: A mode write with cm=0 and rd=0 has no effect. busy_o stays low, the data register is unchanged and the connection memory is unchanged.
- R6: When bid=1 and cac=0 on a write, a second entry {0, index(destination)} is stored at index(source). The loop flag applies only to the first entry.
- R7: When cac=1 on a write, bid is ignored. The data register value is written to every raw address from the destination register up to 0xFF. At the end the destination register reads 0xFF, and the entries below the start are unchanged.
- R8: When cac=1 on a read, the entry at the raw destination address is loaded. Each later processor read of the data register advances the destination register and loads the next entry. After the read of entry 0xFF, further reads change neither the data nor the destination register.
- R9: While busy_o is high, register writes are ignored.
- R10: A switching-side read presents the entry at sw_rd_addr_i on sw_rd_data_o one cycle later and always wins the port. The controller stalls and completes its access afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_re_i | input | 1 | register read strobe (advances a cyclic read) |
| reg_addr_i | input | 2 | register offset |
| reg_wdata_i | input | 9 | register write data |
| reg_rdata_o | output | 9 | register read data (combinational) |
| busy_o | output | 1 | operation in progress |
| sw_rd_en_i | input | 1 | switching-side connection read request |
| sw_rd_addr_i | input | 8 | switching-side read address |
| sw_rd_data_o | output | 9 | switching-side read data, one cycle after request |
| dm_wr_en_i | input | 1 | data-memory write strobe from the receive side |
| dm_wr_addr_i | input | 8 | data-memory write address |
| dm_wr_data_i | input | 8 | data-memory write data |

## Verification
Single writes use destination and source values spread over all field combinations, with the loop flag alternating. A full cyclic read-back then shows whether the slot remapping is right and whether any extra entry was disturbed. Two-way setups with the loop flag set show whether the flag leaks into the reverse entry. A fill started mid-memory is run while switching-side reads are injected and protected registers are rewritten, which separates correct stalling, correct end address and dropped writes from a fill that overruns or loses cycles. Every data-memory address is read once, and a cm=0 write is tried, to tell apart the read-only path and the ignored write.

// File: rtl/tsw_pkg.sv
`timescale 1ns/1ps
package tsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_A, ST_WR_B, ST_FILL, ST_RD_REQ, ST_RD_CAP
  } state_e;

  typedef struct packed {
    logic cac;
    logic bid;
    logic cm;
    logic rd;
  } mode_t;

  localparam logic [1:0] RA_DST  = 2'd0;
  localparam logic [1:0] RA_SRC  = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_MODE = 2'd3;
endpackage

// File: rtl/tsw_cmem_arb.sv
`timescale 1ns/1ps
module tsw_cmem_arb #(
  parameter int ADDR_W = 8,
  parameter int DW     = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              sw_en_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic              ctl_req_i,
  input  logic              ctl_we_i,
  input  logic [ADDR_W-1:0] ctl_addr_i,
  input  logic [DW-1:0]     ctl_wdata_i,
  output logic              ctl_gnt_o,
  output logic [DW-1:0]     q_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_r;

  // switching side owns the port whenever it asks
  assign ctl_gnt_o = ctl_req_i & ~sw_en_i;
  assign q_o       = q_r;

  always_ff @(posedge clk_i) begin
    if (sw_en_i) begin
      q_r <= mem[sw_addr_i];
    end else if (ctl_req_i) begin
      if (ctl_we_i) mem[ctl_addr_i] <= ctl_wdata_i;
      else          q_r <= mem[ctl_addr_i];
    end
  end
endmodule

// File: rtl/tsw_dmem.sv
`timescale 1ns/1ps
module tsw_dmem #(
  parameter int ADDR_W = 8,
  parameter int DW     = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     q_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) q_o <= mem[raddr_i];
  end
endmodule

// File: rtl/tsw_ctrl_fsm.sv
`timescale 1ns/1ps
module tsw_ctrl_fsm
  import tsw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TS_W   = 5,
  parameter int DM_W   = 8,
  localparam int REG_W = ADDR_W + 1,
  localparam int MD_W  = $bits(mode_t)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              busy_o,
  output logic              cm_req_o,
  output logic              cm_we_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [REG_W-1:0]  cm_wdata_o,
  input  logic              cm_gnt_i,
  input  logic [REG_W-1:0]  cm_q_i,
  output logic              dm_re_o,
  output logic [ADDR_W-1:0] dm_addr_o,
  input  logic [DM_W-1:0]   dm_q_i,
  output logic [ADDR_W-1:0] dst_o,
  output logic [ADDR_W-1:0] src_o
);
  state_e            state_q;
  mode_t             mode_q;
  mode_t             mode_w;
  logic [ADDR_W-1:0] dst_q, src_q;
  logic [REG_W-1:0]  data_q;
  logic              cyc_q;
  logic              rd_dm_q;
  logic [ADDR_W-1:0] dst_idx, src_idx;

  // timeslot parity bit becomes the index LSB
  function automatic logic [ADDR_W-1:0] slot_idx(input logic [ADDR_W-1:0] r);
    return {r[ADDR_W-1:TS_W+1], r[TS_W-1:0], r[TS_W]};
  endfunction

  assign dst_idx = slot_idx(dst_q);
  assign src_idx = slot_idx(src_q);
  assign mode_w  = mode_t'(reg_wdata_i[MD_W-1:0]);
  assign busy_o  = (state_q != ST_IDLE);
  assign dst_o   = dst_q;
  assign src_o   = src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      dst_q   <= '0;
      src_q   <= '0;
      data_q  <= '0;
      cyc_q   <= 1'b0;
      rd_dm_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (reg_we_i) begin
            unique case (reg_addr_i)
              RA_DST:  dst_q  <= reg_wdata_i[ADDR_W-1:0];
              RA_SRC:  src_q  <= reg_wdata_i[ADDR_W-1:0];
              RA_DATA: data_q <= reg_wdata_i;
              default: begin
                mode_q <= mode_w;
                cyc_q  <= 1'b0;
                if (!mode_w.cm) begin
                  if (mode_w.rd) begin
                    rd_dm_q <= 1'b1;
                    state_q <= ST_RD_REQ;
                  end
                end else if (mode_w.rd) begin
                  rd_dm_q <= 1'b0;
                  cyc_q   <= mode_w.cac;
                  state_q <= ST_RD_REQ;
                end else if (mode_w.cac) begin
                  state_q <= ST_FILL;
                end else begin
                  state_q <= ST_WR_A;
                end
              end
            endcase
          end else if (reg_re_i && reg_addr_i == RA_DATA && cyc_q) begin
            if (&dst_q) begin
              cyc_q <= 1'b0;
            end else begin
              dst_q   <= dst_q + 1'b1;
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_WR_A: if (cm_gnt_i) state_q <= mode_q.bid ? ST_WR_B : ST_IDLE;
        ST_WR_B: if (cm_gnt_i) state_q <= ST_IDLE;
        ST_FILL: begin
          if (cm_gnt_i) begin
            if (&dst_q) state_q <= ST_IDLE;
            else        dst_q   <= dst_q + 1'b1;
          end
        end
        ST_RD_REQ: if (rd_dm_q || cm_gnt_i) state_q <= ST_RD_CAP;
        ST_RD_CAP: begin
          data_q  <= rd_dm_q ? {{(REG_W-DM_W){1'b0}}, dm_q_i} : cm_q_i;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cm_req_o   = 1'b0;
    cm_we_o    = 1'b0;
    cm_addr_o  = dst_idx;
    cm_wdata_o = data_q;
    unique case (state_q)
      ST_WR_A: begin
        cm_req_o   = 1'b1;
        cm_we_o    = 1'b1;
        cm_wdata_o = {data_q[REG_W-1], src_idx};
      end
      ST_WR_B: begin
        cm_req_o   = 1'b1;
        cm_we_o    = 1'b1;
        cm_addr_o  = src_idx;
        cm_wdata_o = {1'b0, dst_idx};
      end
      ST_FILL: begin
        cm_req_o  = 1'b1;
        cm_we_o   = 1'b1;
        cm_addr_o = dst_q;
      end
      ST_RD_REQ: begin
        cm_req_o  = !rd_dm_q;
        cm_addr_o = mode_q.cac ? dst_q : dst_idx;
      end
      default: ;
    endcase
  end

  assign dm_re_o   = (state_q == ST_RD_REQ) && rd_dm_q;
  assign dm_addr_o = dst_q;

  always_comb begin
    unique case (reg_addr_i)
      RA_DST:  reg_rdata_o = {1'b0, dst_q};
      RA_SRC:  reg_rdata_o = {1'b0, src_q};
      RA_DATA: reg_rdata_o = data_q;
      default: reg_rdata_o = {{(REG_W-MD_W){1'b0}}, mode_q};
    endcase
  end
endmodule

// File: rtl/tsw_cmem_ctrl.sv
`timescale 1ns/1ps
module tsw_cmem_ctrl #(
  parameter int ADDR_W = 8,
  parameter int TS_W   = 5,
  parameter int DM_W   = 8,
  localparam int REG_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              busy_o,
  input  logic              sw_rd_en_i,
  input  logic [ADDR_W-1:0] sw_rd_addr_i,
  output logic [REG_W-1:0]  sw_rd_data_o,
  input  logic              dm_wr_en_i,
  input  logic [ADDR_W-1:0] dm_wr_addr_i,
  input  logic [DM_W-1:0]   dm_wr_data_i
);
  logic              cm_req, cm_we, cm_gnt;
  logic [ADDR_W-1:0] cm_addr;
  logic [REG_W-1:0]  cm_wdata, cm_q;
  logic              dm_re;
  logic [ADDR_W-1:0] dm_addr;
  logic [DM_W-1:0]   dm_q;
  logic [ADDR_W-1:0] dst_q, src_q;

  tsw_ctrl_fsm #(.ADDR_W(ADDR_W), .TS_W(TS_W), .DM_W(DM_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .busy_o      (busy_o),
    .cm_req_o    (cm_req),
    .cm_we_o     (cm_we),
    .cm_addr_o   (cm_addr),
    .cm_wdata_o  (cm_wdata),
    .cm_gnt_i    (cm_gnt),
    .cm_q_i      (cm_q),
    .dm_re_o     (dm_re),
    .dm_addr_o   (dm_addr),
    .dm_q_i      (dm_q),
    .dst_o       (dst_q),
    .src_o       (src_q)
  );

  tsw_cmem_arb #(.ADDR_W(ADDR_W), .DW(REG_W)) u_cmem (
    .clk_i       (clk_i),
    .sw_en_i     (sw_rd_en_i),
    .sw_addr_i   (sw_rd_addr_i),
    .ctl_req_i   (cm_req),
    .ctl_we_i    (cm_we),
    .ctl_addr_i  (cm_addr),
    .ctl_wdata_i (cm_wdata),
    .ctl_gnt_o   (cm_gnt),
    .q_o         (cm_q)
  );

  assign sw_rd_data_o = cm_q;

  tsw_dmem #(.ADDR_W(ADDR_W), .DW(DM_W)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_wr_en_i),
    .waddr_i (dm_wr_addr_i),
    .wdata_i (dm_wr_data_i),
    .re_i    (dm_re),
    .raddr_i (dm_addr),
    .q_o     (dm_q)
  );
endmodule

// File: rtl/tsw_cmem_ctrl_chk.sv
`timescale 1ns/1ps
module tsw_cmem_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [1:0]        mode_lo_i,
  input logic              sw_rd_en_i,
  input logic              cm_gnt,
  input logic [ADDR_W-1:0] dst_q,
  input logic [ADDR_W-1:0] src_q
);
  p_sw_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rd_en_i |-> !cm_gnt);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cm_gnt);

  p_src_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_i && reg_addr_i == 2'd1) |=> $stable(src_q));

  p_dst_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_i && reg_addr_i == 2'd0 && !cm_gnt) |=> $stable(dst_q));

  p_dm_write_noop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && reg_we_i && reg_addr_i == 2'd3 && mode_lo_i == 2'b00) |=> !busy_o);
endmodule

bind tsw_cmem_ctrl tsw_cmem_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .mode_lo_i  (reg_wdata_i[1:0]),
  .sw_rd_en_i (sw_rd_en_i),
  .cm_gnt     (cm_gnt),
  .dst_q      (dst_q),
  .src_q      (src_q)
);

// File: tb/tsw_cmem_ctrl_tb.sv
`timescale 1ns/1ps
module tsw_cmem_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic       busy;
  logic       sw_en = 1'b0;
  logic [7:0] sw_addr = '0;
  logic [8:0] sw_data;
  logic       dm_we = 1'b0;
  logic [7:0] dm_waddr = '0, dm_wdata = '0;

  int total = 0, bad = 0;
  logic [8:0] exp_cm [256];

  always #2.5 clk = ~clk;

  tsw_cmem_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .busy_o(busy),
    .sw_rd_en_i(sw_en), .sw_rd_addr_i(sw_addr), .sw_rd_data_o(sw_data),
    .dm_wr_en_i(dm_we), .dm_wr_addr_i(dm_waddr), .dm_wr_data_i(dm_wdata)
  );

  function automatic logic [7:0] idx(input logic [7:0] r);
    return {r[7:6], r[4:0], r[5]};
  endfunction

  function automatic logic [7:0] dm_val(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [8:0] v);
    reg_addr = a; reg_re = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
    wait_idle();
  endtask

  task automatic verify_all(input string tag);
    logic [8:0] v;
    wr(2'd0, 9'h000);
    wr(2'd3, 9'h00B);
    wait_idle();
    for (int i = 0; i < 256; i++) begin
      rd(2'd2, v);
      chk(tag, v, exp_cm[i]);
    end
    rd(2'd2, v);
    chk("R8 data held after end", v, exp_cm[255]);
    rd(2'd0, v);
    chk("R8 dst held at end", v, 9'h0FF);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] v;
    logic [7:0] d, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {8'h0, busy}, 9'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg zero", v, 9'h0);
    end

    // R7 clear whole memory from 0
    wr(2'd2, 9'h000); wr(2'd0, 9'h000); wr(2'd3, 9'h00A);
    chk("R7 busy during fill", {8'h0, busy}, 9'h1);
    wait_idle();
    for (int i = 0; i < 256; i++) exp_cm[i] = 9'h000;
    rd(2'd0, v);
    chk("R7 dst ends at FF", v, 9'h0FF);

    // R4 data memory reads, every address
    for (int i = 0; i < 256; i++) begin
      dm_we = 1'b1; dm_waddr = 8'(i); dm_wdata = dm_val(i);
      @(negedge clk);
    end
    dm_we = 1'b0;
    for (int i = 0; i < 256; i++) begin
      wr(2'd2, 9'h1FF);
      wr(2'd0, 9'(i));
      wr(2'd3, 9'h001);
      wait_idle();
      rd(2'd2, v);
      chk("R4 dm read", v, {1'b0, dm_val(i)});
    end

    // R5 cm=0 write has no effect
    wr(2'd2, 9'h1A5);
    wr(2'd3, 9'h000);
    chk("R5 not busy", {8'h0, busy}, 9'h0);
    rd(2'd2, v);
    chk("R5 data unchanged", v, 9'h1A5);

    // R2 single writes, R3 single read back
    for (int j = 0; j < 8; j++) begin
      d = 8'((j * 37 + 5) & 255);
      s = 8'((j * 53 + 11) & 255);
      wr(2'd0, {1'b0, d}); wr(2'd1, {1'b0, s});
      wr(2'd2, {1'(j & 1), 8'h00});
      wr(2'd3, 9'h002);
      wait_idle();
      exp_cm[idx(d)] = {1'(j & 1), idx(s)};
      wr(2'd2, 9'h000);
      wr(2'd3, 9'h003);
      wait_idle();
      rd(2'd2, v);
      chk("R3 single read", v, exp_cm[idx(d)]);
    end

    // R6 two-way setup, loop on forward entry only
    for (int j = 0; j < 6; j++) begin
      d = 8'((j * 29 + 130) & 255);
      s = 8'((j * 61 + 3) & 255);
      if (idx(d) != idx(s)) begin
        wr(2'd0, {1'b0, d}); wr(2'd1, {1'b0, s});
        wr(2'd2, 9'h100);
        wr(2'd3, 9'h006);
        wait_idle();
        exp_cm[idx(d)] = {1'b1, idx(s)};
        exp_cm[idx(s)] = {1'b0, idx(d)};
      end
    end
    verify_all("R2 R6 R8 sweep");

    // R7 fill from 0x40 with bid set, R9 writes while busy, R10 conflicts
    wr(2'd2, 9'h12C); wr(2'd1, 9'h044); wr(2'd0, 9'h040);
    wr(2'd3, 9'h00E);
    wr(2'd1, 9'h099);
    wr(2'd0, 9'h010);
    wr(2'd2, 9'h077);
    for (int k = 0; k < 20; k++) begin
      sw_en = 1'b1; sw_addr = 8'(k * 3);
      @(negedge clk);
      chk("R10 sw read", sw_data, exp_cm[k * 3]);
      sw_en = 1'b0;
      @(negedge clk);
    end
    chk("R10 stalled fill still busy", {8'h0, busy}, 9'h1);
    wait_idle();
    for (int i = 64; i < 256; i++) exp_cm[i] = 9'h12C;
    rd(2'd1, v);
    chk("R9 src write ignored", v, 9'h044);
    rd(2'd2, v);
    chk("R9 data write ignored", v, 9'h12C);
    rd(2'd0, v);
    chk("R7 dst ends at FF", v, 9'h0FF);
    verify_all("R7 fill sweep");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule